// File: doc/BRIEF.md
# Write Burst Sequencer with Chopped Bursts and CRC Slot

This block sits in the write path of a double-data-rate DRAM controller. It accepts write commands (a one-cycle valid pulse carrying column, bank group, four payload words and a placeholder CRC value) and turns each one into a fixed schedule of controller clocks. Each clock carries two unit intervals. A burst always fills five clocks: two clocks of payload (four beats), two clocks of all-ones filler and one clock of CRC. The first payload clock appears a fixed write latency after the command. The schedule also drives the strobe-enable, the preamble and postamble flags and a write-recovery reference pulse.

Commands spaced at least `MIN_GAP` clocks apart stream back-to-back with no break in the strobe. A command that comes too soon is dropped and flagged. Pending commands wait in a small queue. A delay line releases them at the right cycle. An output state machine with the states IDLE, PRE, BURST, POST and TURN shapes the strobe. The transitions are as follows. From IDLE, POST or TURN the machine enters PRE when a burst will start in two cycles, and otherwise goes to IDLE. It enters BURST at slot 0 whenever a queued burst is released, from any state, so that BURST slot 4 leads straight into BURST slot 0. BURST steps through slots 0 to 4. After slot 4, if no burst follows, it leaves to POST, or to TURN when the next burst starts after exactly one idle clock.

Top module: `wr_burst_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, strobe_en, preamble, postamble, recov_pulse, spacing_err and busy are 0, and slot_kind is 0 (idle). An asynchronous reset in the middle of a burst returns all of these to 0 at once.
- R2: A command accepted in cycle c produces slots 0..4 in cycles c+WL .. c+WL+4 (WL = 9 by default). The slot_kind codes are: 2'b01 payload for slots 0-1, 2'b10 filler for slots 2-3, 2'b11 CRC for slot 4, and 2'b00 outside a burst. slot_idx gives the slot number.
- R3: dq_pair carries words {1,0} of cmd_data (cmd_data[31:0]) in slot 0 and words {3,2} (cmd_data[63:32]) in slot 1. It is all ones in slots 2-3, carries cmd_crc in slot 4, and is 0 outside a burst.
- R4: The cycle before slot 0 has preamble = 1 and strobe_en = 1 when that cycle is not itself a burst slot. strobe_en is 1 in every burst slot.
- R5: A second command accepted exactly MIN_GAP (5) clocks after the first starts its slot 0 in the cycle right after the first burst's CRC slot. No preamble, postamble or recovery pulse appears between the two bursts.
- R6: In the cycle after a CRC slot that is not followed at once by a new slot 0, postamble = 1, recov_pulse = 1 for one cycle and strobe_en = 1. In the cycle after that, strobe_en is 0 unless a new preamble or burst follows.
- R7: A command arriving fewer than MIN_GAP clocks after the last accepted command is dropped. spacing_err is 1 in the next cycle, and the dropped command produces no burst.
- R8: A dropped command does not restart the spacing window. A command MIN_GAP clocks after the last accepted one is accepted even if a dropped one came in between.
- R9: busy is 1 from the cycle after acceptance through the last CRC slot, and is 0 in the postamble cycle of the last burst.
- R10: When the next burst starts after exactly one idle clock, that clock has preamble, postamble, recov_pulse and strobe_en all 1, with slot_kind 0.
- R11: burst_col and burst_bg show the column and bank group of the command whose burst is in progress. Either bank group is accepted at the minimum spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle write command strobe |
| cmd_col | input | COL_W | Column address of the command |
| cmd_bg | input | BG_W | Bank group of the command |
| cmd_data | input | 4*DW | Four payload words, word 0 in the low bits |
| cmd_crc | input | 2*DW | Placeholder CRC for the burst |
| strobe_en | output | 1 | Data strobe drive enable |
| preamble | output | 1 | Preamble clock flag |
| postamble | output | 1 | Postamble clock flag |
| slot_idx | output | 3 | Slot number 0..4 within the burst |
| slot_kind | output | 2 | 00 idle, 01 payload, 10 filler, 11 CRC |
| dq_pair | output | 2*DW | Two beats of the current clock, first beat in the low bits |
| burst_col | output | COL_W | Column of the burst in progress |
| burst_bg | output | BG_W | Bank group of the burst in progress |
| recov_pulse | output | 1 | Write recovery / turnaround reference pulse |
| spacing_err | output | 1 | A command was dropped for spacing |
| busy | output | 1 | A burst is queued or in progress |

## Verification
The assertions assume that cmd_valid is a clean one-cycle pulse. They also assume that only the spacing guard feeds the queue, so its depth, derived from WL and MIN_GAP, can never overflow, and that a new slot 0 can only follow a CRC slot or a non-burst cycle. The stimulus drives every command for a single cycle at a falling edge. It uses fixed schedules of gaps (0/5, 0/6, 0/7, a drop at 4, and a drop at 3 followed by an accept at 5), which cover every state transition while staying inside those assumptions.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    typedef enum logic [1:0] {
        KIND_IDLE = 2'b00,
        KIND_DATA = 2'b01,
        KIND_FILL = 2'b10,
        KIND_CRC  = 2'b11
    } slot_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_BURST,
        ST_POST,
        ST_TURN
    } seq_state_e;
endpackage

// File: rtl/wbs_gap_guard.sv
module wbs_gap_guard #(
    parameter int MIN_GAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    output logic accept,
    output logic spacing_err
);
    localparam int CW = $clog2(MIN_GAP + 1);

    logic [CW-1:0] since;

    assign accept = cmd_valid && (since >= CW'(MIN_GAP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since       <= CW'(MIN_GAP);
            spacing_err <= 1'b0;
        end else begin
            spacing_err <= cmd_valid && !accept;
            if (accept)
                since <= CW'(1);
            else if (since < CW'(MIN_GAP))
                since <= since + 1'b1;
        end
    end

    AST_ERR_NOT_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n) spacing_err |-> !$past(accept)); // R7
    AST_ACCEPT_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !accept); // R8
endmodule

// File: rtl/wbs_cmd_queue.sv
module wbs_cmd_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R2
endmodule

// File: rtl/wbs_launch_line.sv
module wbs_launch_line #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic tap_pre,
    output logic tap_go
);
    logic [LEN-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr <= '0;
        else
            sr <= {sr[LEN-2:0], din};
    end

    assign tap_go  = sr[LEN-1];
    assign tap_pre = sr[LEN-2];

    AST_GO_FOLLOWS_PRE: assert property (@(posedge clk) disable iff (!rst_n) tap_pre |=> tap_go); // R4
endmodule

// File: rtl/wr_burst_seq.sv
module wr_burst_seq
    import wbs_pkg::*;
#(
    parameter int DW      = 16,
    parameter int COL_W   = 10,
    parameter int BG_W    = 2,
    parameter int WL      = 9,
    parameter int MIN_GAP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [BG_W-1:0]   cmd_bg,
    input  logic [4*DW-1:0]   cmd_data,
    input  logic [2*DW-1:0]   cmd_crc,
    output logic              strobe_en,
    output logic              preamble,
    output logic              postamble,
    output logic [2:0]        slot_idx,
    output logic [1:0]        slot_kind,
    output logic [2*DW-1:0]   dq_pair,
    output logic [COL_W-1:0]  burst_col,
    output logic [BG_W-1:0]   burst_bg,
    output logic              recov_pulse,
    output logic              spacing_err,
    output logic              busy
);
    localparam int DATA_SLOTS = 2;
    localparam int FILL_SLOTS = 2;
    localparam int SLOTS      = DATA_SLOTS + FILL_SLOTS + 1;
    localparam int LAST       = SLOTS - 1;
    localparam int PW         = COL_W + BG_W + 4*DW + 2*DW;
    localparam int QDEPTH     = (WL - 1) / MIN_GAP + 2;

    logic          accept, go, pre_soon, q_empty, q_full;
    logic [PW-1:0] q_head, cur;
    seq_state_e    state, nxt;
    logic [2:0]    slot, nxt_slot;

    wbs_gap_guard #(.MIN_GAP(MIN_GAP)) u_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .accept(accept), .spacing_err(spacing_err)
    );

    wbs_cmd_queue #(.W(PW), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(accept), .pop(go),
        .wdata({cmd_col, cmd_bg, cmd_data, cmd_crc}),
        .head(q_head), .empty(q_empty), .full(q_full)
    );

    wbs_launch_line #(.LEN(WL - 1)) u_line (
        .clk(clk), .rst_n(rst_n), .din(accept),
        .tap_pre(pre_soon), .tap_go(go)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
            cur   <= '0;
        end else begin
            state <= nxt;
            slot  <= nxt_slot;
            if (go)
                cur <= q_head;
        end
    end

    // next state
    always_comb begin
        nxt      = state;
        nxt_slot = slot;
        unique case (state)
            ST_BURST: begin
                if (go) begin
                    nxt      = ST_BURST;
                    nxt_slot = '0;
                end else if (slot != 3'(LAST)) begin
                    nxt_slot = slot + 1'b1;
                end else begin
                    nxt      = pre_soon ? ST_TURN : ST_POST;
                    nxt_slot = '0;
                end
            end
            default: begin
                nxt_slot = '0;
                if (go)
                    nxt = ST_BURST;
                else
                    nxt = pre_soon ? ST_PRE : ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        strobe_en   = 1'b0;
        preamble    = 1'b0;
        postamble   = 1'b0;
        recov_pulse = 1'b0;
        slot_idx    = '0;
        slot_kind   = KIND_IDLE;
        dq_pair     = '0;
        burst_col   = '0;
        burst_bg    = '0;
        unique case (state)
            ST_IDLE: ;
            ST_PRE: begin
                strobe_en = 1'b1;
                preamble  = 1'b1;
            end
            ST_POST: begin
                strobe_en   = 1'b1;
                postamble   = 1'b1;
                recov_pulse = 1'b1;
            end
            ST_TURN: begin
                strobe_en   = 1'b1;
                preamble    = 1'b1;
                postamble   = 1'b1;
                recov_pulse = 1'b1;
            end
            ST_BURST: begin
                strobe_en = 1'b1;
                slot_idx  = slot;
                burst_col = cur[PW-1 -: COL_W];
                burst_bg  = cur[PW-COL_W-1 -: BG_W];
                if (slot < 3'(DATA_SLOTS)) begin
                    slot_kind = KIND_DATA;
                    dq_pair   = cur[2*DW + slot[0]*2*DW +: 2*DW];
                end else if (slot < 3'(LAST)) begin
                    slot_kind = KIND_FILL;
                    dq_pair   = '1;
                end else begin
                    slot_kind = KIND_CRC;
                    dq_pair   = cur[2*DW-1:0];
                end
            end
            default: ;
        endcase
    end

    assign busy = !q_empty || (state == ST_BURST);

    AST_PRE_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n) preamble |=> (slot_kind == KIND_DATA && slot_idx == 3'd0)); // R4
    AST_RECOV_AFTER_CRC: assert property (@(posedge clk) disable iff (!rst_n) recov_pulse |-> $past(slot_kind == KIND_CRC)); // R6
    AST_CRC_THEN_DATA_OR_POST: assert property (@(posedge clk) disable iff (!rst_n) (slot_kind == KIND_CRC) |=> ((slot_kind == KIND_DATA && slot_idx == 3'd0) || postamble)); // R5
    AST_NEW_BURST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n) (slot_kind == KIND_DATA && slot_idx == 3'd0) |-> !($past(slot_kind) != KIND_IDLE && $past(slot_idx) != 3'(LAST))); // R7
    AST_QUEUE_ROOM: assert property (@(posedge clk) disable iff (!rst_n) accept |-> !q_full); // R8
endmodule

// File: tb/wr_burst_seq_test.sv
module wr_burst_seq_test;
    typedef struct packed {
        logic [9:0]  col;
        logic [1:0]  bg;
        logic [63:0] data;
        logic [31:0] crc;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{10'h005, 2'd0, 64'h4444_3333_2222_1111, 32'hC0DE_0001},
        '{10'h3FF, 2'd3, 64'h0000_0000_0000_0000, 32'h0000_0000},
        '{10'h12A, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF},
        '{10'h200, 2'd2, 64'hDEAD_BEEF_0BAD_F00D, 32'h1234_5678}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic [9:0]  cmd_col = '0;
    logic [1:0]  cmd_bg = '0;
    logic [63:0] cmd_data = '0;
    logic [31:0] cmd_crc = '0;
    logic        strobe_en, preamble, postamble, recov_pulse, spacing_err, busy;
    logic [2:0]  slot_idx;
    logic [1:0]  slot_kind;
    logic [31:0] dq_pair;
    logic [9:0]  burst_col;
    logic [1:0]  burst_bg;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wr_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
        .cmd_bg(cmd_bg), .cmd_data(cmd_data), .cmd_crc(cmd_crc),
        .strobe_en(strobe_en), .preamble(preamble), .postamble(postamble),
        .slot_idx(slot_idx), .slot_kind(slot_kind), .dq_pair(dq_pair),
        .burst_col(burst_col), .burst_bg(burst_bg), .recov_pulse(recov_pulse),
        .spacing_err(spacing_err), .busy(busy)
    );

    localparam int NCYC = 40;
    logic [1:0]  lk [NCYC];
    logic [2:0]  li [NCYC];
    logic [31:0] ld [NCYC];
    logic [9:0]  lc [NCYC];
    logic [1:0]  lg [NCYC];
    logic        lpre [NCYC], lpost [NCYC], lrec [NCYC], lstb [NCYC], lerr [NCYC], lbusy [NCYC];

    vec_t pa, pb, pc;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_kind(input int s);
        return (s < 2) ? 2'b01 : (s < 4) ? 2'b10 : 2'b11;
    endfunction

    function automatic logic [31:0] exp_dq(input vec_t v, input int s);
        case (s)
            0: return v.data[31:0];
            1: return v.data[63:32];
            4: return v.crc;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic drive(input logic v, input vec_t p);
        cmd_valid = v;
        cmd_col   = v ? p.col  : '0;
        cmd_bg    = v ? p.bg   : '0;
        cmd_data  = v ? p.data : '0;
        cmd_crc   = v ? p.crc  : '0;
    endtask

    // commands at cycles ta, tb, tc (-1 = none), outputs logged per cycle
    task automatic run_sched(input int ta, input int tb, input int tc);
        for (int k = 0; k < NCYC; k++) begin
            @(negedge clk);
            lk[k] = slot_kind; li[k] = slot_idx; ld[k] = dq_pair;
            lc[k] = burst_col; lg[k] = burst_bg;
            lpre[k] = preamble; lpost[k] = postamble; lrec[k] = recov_pulse;
            lstb[k] = strobe_en; lerr[k] = spacing_err; lbusy[k] = busy;
            if (k == ta)      drive(1'b1, pa);
            else if (k == tb) drive(1'b1, pb);
            else if (k == tc) drive(1'b1, pc);
            else              drive(1'b0, pa);
        end
    endtask

    task automatic check_burst(input string req, input int base, input vec_t v);
        for (int s = 0; s < 5; s++) begin
            chk({req, " R2 kind"}, lk[base+s], exp_kind(s));
            chk({req, " R2 idx"},  li[base+s], s);
            chk({req, " R3 dq"},   ld[base+s], exp_dq(v, s));
            chk({req, " R4 strobe in slot"}, lstb[base+s], 1);
            chk({req, " R11 col"}, lc[base+s], v.col);
            chk({req, " R11 bg"},  lg[base+s], v.bg);
        end
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", strobe_en, 0);
        chk("R1 busy in reset", busy, 0);
        chk("R1 kind in reset", slot_kind, 0);
        chk("R1 err in reset", spacing_err, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 preamble after reset", preamble, 0);
        chk("R1 postamble after reset", postamble, 0);
        chk("R1 recov after reset", recov_pulse, 0);

        // table of single bursts
        for (int i = 0; i < 4; i++) begin
            pa = VECS[i];
            run_sched(0, -1, -1);
            chk("R4 no strobe before preamble", lstb[7], 0);
            chk("R4 preamble", lpre[8], 1);
            chk("R4 strobe in preamble", lstb[8], 1);
            chk("R4 idle kind in preamble", lk[8], 0);
            check_burst("single", 9, VECS[i]);
            chk("R6 postamble", lpost[14], 1);
            chk("R6 recov", lrec[14], 1);
            chk("R6 strobe in postamble", lstb[14], 1);
            chk("R6 recov one cycle", lrec[15], 0);
            chk("R6 strobe off", lstb[15], 0);
            chk("R9 busy idle before", lbusy[0], 0);
            chk("R9 busy after accept", lbusy[1], 1);
            chk("R9 busy last slot", lbusy[13], 1);
            chk("R9 busy cleared", lbusy[14], 0);
            chk("R7 no error", lerr[1], 0);
            chk("R3 dq idle", ld[15], 0);
        end

        // R5 back-to-back at minimum spacing, different bank group
        pa = VECS[0]; pb = VECS[3];
        run_sched(0, 5, -1);
        check_burst("b2b first", 9, VECS[0]);
        check_burst("b2b second", 14, VECS[3]);
        chk("R5 no preamble", lpre[14], 0);
        chk("R5 no postamble", lpost[14], 0);
        chk("R5 no recov", lrec[14], 0);
        chk("R5 no preamble before second", lpre[13], 0);
        chk("R6 postamble after last", lpost[19], 1);
        chk("R6 recov after last", lrec[19], 1);
        chk("R9 busy between", lbusy[14], 1);
        chk("R6 strobe off end", lstb[20], 0);

        // R10 one idle clock between bursts
        pa = VECS[1]; pb = VECS[2];
        run_sched(0, 6, -1);
        chk("R10 preamble", lpre[14], 1);
        chk("R10 postamble", lpost[14], 1);
        chk("R10 recov", lrec[14], 1);
        chk("R10 strobe", lstb[14], 1);
        chk("R10 idle kind", lk[14], 0);
        check_burst("gap1 second", 15, VECS[2]);
        chk("R6 post after gap1", lpost[20], 1);

        // two idle clocks: separate postamble and preamble
        pa = VECS[2]; pb = VECS[0];
        run_sched(0, 7, -1);
        chk("R6 postamble gap2", lpost[14], 1);
        chk("R4 no preamble with post", lpre[14], 0);
        chk("R4 preamble gap2", lpre[15], 1);
        chk("R6 no post in preamble", lpost[15], 0);
        chk("R6 no recov in preamble", lrec[15], 0);
        check_burst("gap2 second", 16, VECS[0]);

        // R7 rejected command
        pa = VECS[3]; pb = VECS[1];
        run_sched(0, 4, -1);
        chk("R7 no err early", lerr[4], 0);
        chk("R7 err flagged", lerr[5], 1);
        chk("R7 err one cycle", lerr[6], 0);
        check_burst("reject first", 9, VECS[3]);
        chk("R7 no burst from dropped", lk[14], 0);
        chk("R7 postamble kept", lpost[14], 1);
        chk("R7 idle after", lk[15], 0);
        chk("R7 strobe off", lstb[16], 0);
        chk("R9 busy not held by dropped", lbusy[14], 0);

        // R8 dropped command does not restart window
        pa = VECS[0]; pb = VECS[2]; pc = VECS[1];
        run_sched(0, 3, 5);
        chk("R8 drop flagged", lerr[4], 1);
        chk("R8 accept at min gap", lerr[6], 0);
        chk("R8 no preamble", lpre[13], 0);
        check_burst("window", 14, VECS[1]);

        // R1 reset in the middle of a burst
        pa = VECS[2];
        @(negedge clk);
        drive(1'b1, pa);
        @(negedge clk);
        drive(1'b0, pa);
        repeat (9) @(negedge clk);
        chk("R1 burst running before reset", slot_kind, 2'b01);
        rst_n = 0;
        #1;
        chk("R1 strobe after async reset", strobe_en, 0);
        chk("R1 kind after async reset", slot_kind, 0);
        chk("R1 busy after async reset", busy, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (8) @(negedge clk);
        chk("R1 no stale burst", slot_kind, 0);
        chk("R1 no stale postamble", postamble, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule